// File: doc/BRIEF.md
# PWM Safety Watchdog

This block guards a general-purpose PWM output against a stalled host. An 8-bit down-counter is preloaded from an 8-bit reload field. The counter loses one step on each pulse of a slow tick enable, which runs at 5 Hz, so one step is 200 ms. Any host write of the configuration register or of the duty byte reloads the counter, and that write is the watchdog kick.

If the count runs out, the block does two things. It forces the 2-bit PWM control-mode output to 3, which drives the PWM fully on. It also sets a sticky status flag. The interrupt line is that flag gated by an enable bit.

The host reaches the block through a single-cycle write port with a 2-bit address. The downstream PWM generator reads the control mode and the duty byte from the outputs.

Top module: `pwm_safety_wdog`

## Requirements
- R1: After reset, pwm_mode is 0, duty_min is 0, irq is 0, the interrupt enable is 0 and the reload field is 0x14. The counter holds 0x14, so expiry comes on the 20th tick.
- R2: A write to address 0 is the configuration write. It stores wr_data[1:0] as the control mode, wr_data[2] as the interrupt enable and wr_data[15:8] as the reload field. It also loads the counter with the newly written reload value.
- R3: A write to address 1 stores wr_data[7:0] on duty_min and reloads the counter from the stored reload field.
- R4: When the counter is non-zero, each cycle with tick high lowers it by one. While tick stays low, the counter keeps its value and resumes from it when tick returns.
- R5: When a tick moves the counter from 1 to 0, pwm_mode becomes 3 and the sticky flag is set, both visible in the cycle after that edge. duty_min, the enable and the reload field do not change.
- R6: irq equals the sticky flag AND the enable. A write to address 2 with wr_data[0]=1 clears the flag, and with wr_data[0]=0 it leaves the flag unchanged. If an expiry and a clear land in the same cycle, the flag stays set.
- R7: A reload value of 0 disables the watchdog: any number of ticks causes no expiry.
- R8: If a kick and a tick land in the same cycle, the reload wins and no expiry occurs. A counter at 0 stays at 0 and does not expire again until it is reloaded.
- R9: A write to address 3 changes no output and does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | 0 config, 1 duty, 2 status clear, 3 unused |
| wr_data | input | 16 | Write data |
| tick | input | 1 | 5 Hz step enable, one cycle wide |
| irq | output | 1 | Interrupt request |
| pwm_mode | output | 2 | Control mode to the PWM, 3 = full on |
| duty_min | output | 8 | Duty byte to the PWM |

## Verification
The hardest cases to reach are the collisions. One is a kick landing on the very tick that would take the counter from 1 to 0. The other is a status clear landing on the expiry edge itself. Both are reached by reloading the counter with 1, so that the next tick is the expiring one. The bench then drives the write and the tick in the same cycle through a combined task. The internal count is never read; it is inferred from the exact tick on which pwm_mode turns to 3.

// File: rtl/pwm_wdog_pkg.sv
package pwm_wdog_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_CFG   = 2'd0,
    A_DUTY  = 2'd1,
    A_CLR   = 2'd2,
    A_SPARE = 2'd3
  } wd_addr_e;
  localparam logic [1:0] MODE_FULL_ON = 2'd3;
endpackage

// File: rtl/pwm_wdog_counter.sv
module pwm_wdog_counter #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = 8'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = kick || (tick && (cnt_q != '0));
    cnt_d  = kick ? load_val : (cnt_q - ONE);
    expire = !kick && tick && (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt_q == $past(load_val));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && !tick) |=> $stable(cnt_q));
  p_zero_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && cnt_q == '0) |=> (cnt_q == '0) && !expire);
endmodule

// File: rtl/pwm_wdog_regs.sv
module pwm_wdog_regs
  import pwm_wdog_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 8,
  parameter int DATA_W = 16,
  parameter logic [CNT_W-1:0] RST_RELOAD = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic              kick,
  output logic [CNT_W-1:0]  load_val,
  output logic              irq,
  output logic [1:0]        mode,
  output logic [DUTY_W-1:0] duty
);
  localparam int RLD_LSB = DATA_W - CNT_W;

  logic              cfg_wr, duty_wr, clr_wr;
  logic [1:0]        mode_q, mode_d;
  logic              ien_q, ien_d;
  logic [CNT_W-1:0]  rld_q, rld_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              flag_q, flag_d;

  always_comb begin
    cfg_wr  = wr_en && (wr_addr == A_CFG);
    duty_wr = wr_en && (wr_addr == A_DUTY);
    clr_wr  = wr_en && (wr_addr == A_CLR) && wr_data[0];
    kick    = cfg_wr || duty_wr;
    load_val = cfg_wr ? wr_data[DATA_W-1:RLD_LSB] : rld_q;

    mode_d = mode_q;
    ien_d  = ien_q;
    rld_d  = rld_q;
    duty_d = duty_q;
    flag_d = flag_q;
    if (cfg_wr) begin
      mode_d = wr_data[1:0];
      ien_d  = wr_data[2];
      rld_d  = wr_data[DATA_W-1:RLD_LSB];
    end
    if (duty_wr) duty_d = wr_data[DUTY_W-1:0];
    if (clr_wr)  flag_d = 1'b0;
    if (expire) begin
      mode_d = MODE_FULL_ON;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= 1'b0;
      rld_q  <= RST_RELOAD;
      duty_q <= '0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ien_q  <= ien_d;
      rld_q  <= rld_d;
      duty_q <= duty_d;
      flag_q <= flag_d;
    end
  end

  assign irq  = flag_q && ien_q;
  assign mode = mode_q;
  assign duty = duty_q;

  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (mode_q == MODE_FULL_ON) && flag_q);
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> $stable(duty_q) && $stable(rld_q) && $stable(ien_q));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !flag_q);
  p_spare_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SPARE && !expire) |=> $stable(mode_q) && $stable(duty_q)
      && $stable(rld_q) && $stable(ien_q));
endmodule

// File: rtl/pwm_safety_wdog.sv
module pwm_safety_wdog #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 8,
  parameter int DATA_W = 16,
  parameter logic [CNT_W-1:0] RST_RELOAD = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              irq,
  output logic [1:0]        pwm_mode,
  output logic [DUTY_W-1:0] duty_min
);
  logic             kick, expire;
  logic [CNT_W-1:0] load_val;

  pwm_wdog_regs #(
    .CNT_W(CNT_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W), .RST_RELOAD(RST_RELOAD)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .expire(expire), .kick(kick), .load_val(load_val), .irq(irq),
    .mode(pwm_mode), .duty(duty_min)
  );

  pwm_wdog_counter #(.CNT_W(CNT_W), .RST_VAL(RST_RELOAD)) i_cnt (
    .clk(clk), .rst_n(rst_n), .kick(kick), .load_val(load_val),
    .tick(tick), .expire(expire)
  );

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire) || $past(wr_en && wr_addr == 2'd0));
endmodule

// File: tb/test_pwm_safety_wdog.sv
module test_pwm_safety_wdog;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        irq;
  logic [1:0]  pwm_mode;
  logic [7:0]  duty_min;
  int total = 0;
  int bad = 0;

  pwm_safety_wdog i_pwm_safety_wdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .irq(irq), .pwm_mode(pwm_mode), .duty_min(duty_min)
  );

  always #2 clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven on the falling edge, results sampled on the next falling edge
  task automatic step(bit w, logic [1:0] a, logic [15:0] d, bit t);
    wr_en = w; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic cfg(logic [7:0] rld, bit ien, logic [1:0] m);
    step(1, 2'd0, {rld, 5'd0, ien, m}, 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 16'd0, 1);
  endtask

  task automatic clear();
    step(1, 2'd2, 16'd1, 0);
  endtask

  task automatic t_reset();
    check("R1 mode", pwm_mode, 0);
    check("R1 duty", duty_min, 0);
    check("R1 irq", irq, 0);
    ticks(19);
    check("R1 no expiry at 19", pwm_mode, 0);
    ticks(1);
    check("R5 expiry at 20", pwm_mode, 3);
    check("R1 enable off", irq, 0);
  endtask

  task automatic t_irq();
    cfg(8'd3, 1, 2'd1);
    check("R6 enabled sticky", irq, 1);
    check("R2 mode written", pwm_mode, 1);
    step(1, 2'd2, 16'd0, 0);
    check("R6 zero write keeps flag", irq, 1);
    clear();
    check("R6 clear", irq, 0);
    ticks(2);
    check("R2 new reload 3 not yet", pwm_mode, 1);
    ticks(1);
    check("R5 forced", pwm_mode, 3);
    check("R6 irq on expiry", irq, 1);
    check("R5 duty untouched", duty_min, 0);
  endtask

  task automatic t_duty_kick();
    clear();
    cfg(8'd5, 1, 2'd0);
    ticks(3);
    step(1, 2'd1, 16'h0080, 0);
    check("R3 duty stored", duty_min, 8'h80);
    ticks(4);
    check("R3 reloaded from field", pwm_mode, 0);
    ticks(1);
    check("R3 expiry after full reload", pwm_mode, 3);
    check("R5 duty kept", duty_min, 8'h80);
  endtask

  task automatic t_hold();
    clear();
    cfg(8'd2, 1, 2'd2);
    ticks(1);
    repeat (50) @(negedge clk);
    check("R4 holds without ticks", pwm_mode, 2);
    ticks(1);
    check("R4 resumes", pwm_mode, 3);
  endtask

  task automatic t_collide();
    clear();
    cfg(8'd1, 1, 2'd0);
    step(1, 2'd0, {8'd1, 8'h06}, 1);
    check("R8 reload beats tick", pwm_mode, 2);
    check("R8 no flag", irq, 0);
    ticks(1);
    check("R8 later expiry", pwm_mode, 3);
    clear();
    ticks(5);
    check("R8 zero stays quiet", irq, 0);
    cfg(8'd1, 1, 2'd1);
    step(1, 2'd2, 16'd1, 1);
    check("R6 set beats clear", irq, 1);
  endtask

  task automatic t_disable();
    clear();
    cfg(8'd0, 1, 2'd1);
    ticks(300);
    check("R7 disabled mode", pwm_mode, 1);
    check("R7 disabled irq", irq, 0);
  endtask

  task automatic t_spare();
    cfg(8'd2, 1, 2'd2);
    ticks(1);
    step(1, 2'd3, 16'hFFFF, 0);
    check("R9 mode kept", pwm_mode, 2);
    check("R9 duty kept", duty_min, 8'h80);
    ticks(1);
    check("R9 no reload", pwm_mode, 3);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_duty_kick();
    t_hold();
    t_collide();
    t_disable();
    t_spare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule